// File: doc/BRIEF.md
# Designator-Selected Scratchpad Register Array

This block is the general register store of a small byte-oriented processor core. It keeps sixteen 16-bit registers. The control logic places a 4-bit register index in each of three designators: the operand index (N), the program-counter index (P) and the data-pointer index (X). A two-bit source code then picks which of the three designators chooses the active register for the current cycle.

The active register feeds three paths, and any mix of them may run in the same cycle. The accumulator read path puts either byte of the register on `d_out`. The step path adds or subtracts one and writes the result back into the same register. The address path copies the register and sends it out as two bytes on one 8-bit port, high byte first, with a strobe that marks the first byte. A separate byte-write path puts an 8-bit value into one byte of the active register. This is the path used to load a register one byte at a time, or to replace only the low byte of the program counter when a branch stays within the page.

Instruction decoding, the ALU and memory are outside this block.

Top module: `scratch_array`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers to 0x0000 and sets `addr_valid` low.
- R2: `dsg_src` chooses the active register index: 0 takes `dsg_n`, 1 takes `dsg_p`, and 2 or 3 take `dsg_x`.
- R3: `d_out` shows bits 15:8 of the active register when `byte_hi`=1 and bits 7:0 when `byte_hi`=0. It always shows the value held before the coming clock edge.
- R4: A byte write (`wr_en`=1 with `step_en`=0) replaces the byte of the active register that `byte_hi` selects with `wr_data`, and leaves the other byte unchanged.
- R5: With `step_en`=1 and `step_down`=0, the active register becomes its value plus one, wrapping from 0xFFFF to 0x0000.
- R6: With `step_en`=1 and `step_down`=1, the active register becomes its value minus one, wrapping from 0x0000 to 0xFFFF.
- R7: An `addr_req` in cycle k presents the high byte on `addr_bus` in cycle k+1, with `addr_first`=1 and `addr_valid`=1, and the low byte in cycle k+2, with `addr_first`=0 and `addr_valid`=1. With no further request, `addr_valid` is 0 in cycle k+3.
- R8: When `addr_req` and `step_en` are both asserted in one cycle, the address sent out is the value from before the step.
- R9: When `step_en` and `wr_en` are both asserted in one cycle, the step result is written and the byte write is dropped.
- R10: The read, address and step paths can all work in one cycle, and each uses the value from before the update.
- R11: A write or step changes only the active register. The other fifteen keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dsg_n | input | 4 | Operand designator |
| dsg_p | input | 4 | Program-counter designator |
| dsg_x | input | 4 | Data-pointer designator |
| dsg_src | input | 2 | Chooses the designator: 0=N, 1=P, 2 or 3=X |
| byte_hi | input | 1 | Byte select for the read and write paths (1 = high byte) |
| d_out | output | 8 | Selected byte of the active register |
| wr_en | input | 1 | Byte write enable |
| wr_data | input | 8 | Byte to write |
| step_en | input | 1 | Step and write-back enable |
| step_down | input | 1 | Step direction: 0 adds one, 1 subtracts one |
| addr_req | input | 1 | Start sending the active register as an address |
| addr_bus | output | 8 | Multiplexed address byte |
| addr_first | output | 1 | High when `addr_bus` carries the high byte |
| addr_valid | output | 1 | High while `addr_bus` carries an address byte |

## Verification
The bench aims at the points where a register array like this usually goes wrong. It checks the wrap at 0xFFFF and at 0x0000: a design that lets the carry run past bit 15, or that gets the borrow wrong, shows the wrong neighbour value. It requests an address and a step in the same cycle: a design that captures the address after the write-back sends out the stepped value. It collides a step with a byte write on the same register: a design with the priority reversed ends up holding the written byte. It also checks that a low-byte write through the P designator keeps the high byte, and that registers other than the active one keep their values: a design with a wrong lane mask or index decode corrupts the neighbouring byte or register.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

    // Which designator supplies the active register index.
    typedef enum logic [1:0] {
        DSG_N     = 2'd0,
        DSG_P     = 2'd1,
        DSG_X     = 2'd2,
        DSG_X_ALT = 2'd3
    } dsg_src_e;

    // Lane helpers, kept at the default geometry of 16-bit registers
    // and 8-bit lanes.
    function automatic logic [7:0] upper_lane(input logic [15:0] v);
        return v[15:8];
    endfunction

    function automatic logic [7:0] lower_lane(input logic [15:0] v);
        return v[7:0];
    endfunction

endpackage

// File: rtl/scratch_sel.sv
module scratch_sel
    import scratch_pkg::*;
#(
    parameter int SELW = 4
) (
    input  logic [SELW-1:0] dsg_n,
    input  logic [SELW-1:0] dsg_p,
    input  logic [SELW-1:0] dsg_x,
    input  logic [1:0]      dsg_src,
    output logic [SELW-1:0] sel_idx
);
    dsg_src_e src;

    always_comb begin
        src = dsg_src_e'(dsg_src);
        unique case (src)
            DSG_N:   sel_idx = dsg_n;
            DSG_P:   sel_idx = dsg_p;
            default: sel_idx = dsg_x;
        endcase
    end
endmodule

// File: rtl/scratch_regfile.sv
module scratch_regfile #(
    parameter int REG_COUNT = 16,
    parameter int REG_W     = 16,
    parameter int BYTE_W    = 8,
    localparam int SELW     = $clog2(REG_COUNT)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [SELW-1:0]                sel_idx,
    input  logic                           full_we,
    input  logic [REG_W-1:0]               full_val,
    input  logic                           byte_we,
    input  logic                           byte_hi,
    input  logic [BYTE_W-1:0]              byte_val,
    output logic [REG_COUNT-1:0][REG_W-1:0] bank
);
    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        logic hit;
        assign hit = (sel_idx == SELW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                bank[i] <= '0;
            end else if (hit && full_we) begin
                // A step write-back beats a byte write to the same register.
                bank[i] <= full_val;
            end else if (hit && byte_we) begin
                if (byte_hi) bank[i][REG_W-1 -: BYTE_W] <= byte_val;
                else         bank[i][BYTE_W-1:0]       <= byte_val;
            end
        end
    end
endmodule

// File: rtl/scratch_incdec.sv
module scratch_incdec #(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] val_in,
    input  logic             down,
    output logic [REG_W-1:0] val_out
);
    // The result keeps REG_W bits, so the step wraps around at both ends.
    always_comb begin
        if (down) val_out = val_in - REG_W'(1);
        else      val_out = val_in + REG_W'(1);
    end
endmodule

// File: rtl/scratch_addr_ser.sv
module scratch_addr_ser #(
    parameter int REG_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = REG_W / BYTE_W,
    localparam int CW    = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [REG_W-1:0]  val,
    output logic [BYTE_W-1:0] bus,
    output logic              first,
    output logic              valid
);
    logic [REG_W-1:0] shreg;
    logic [CW-1:0]    cnt;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
        end else if (req) begin
            // Capture the value from before any write-back in this cycle.
            shreg <= val;
            cnt   <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            shreg <= shreg << BYTE_W;
            cnt   <= cnt + CW'(1);
            if (cnt == CW'(NB - 1)) busy <= 1'b0;
        end
    end

    assign bus   = shreg[REG_W-1 -: BYTE_W];
    assign first = busy && (cnt == '0);
    assign valid = busy;
endmodule

// File: rtl/scratch_array.sv
module scratch_array
    import scratch_pkg::*;
#(
    parameter int REG_COUNT = 16,
    parameter int REG_W     = 16,
    parameter int BYTE_W    = 8,
    localparam int SELW     = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SELW-1:0]   dsg_n,
    input  logic [SELW-1:0]   dsg_p,
    input  logic [SELW-1:0]   dsg_x,
    input  logic [1:0]        dsg_src,
    input  logic              byte_hi,
    output logic [BYTE_W-1:0] d_out,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              step_en,
    input  logic              step_down,
    input  logic              addr_req,
    output logic [BYTE_W-1:0] addr_bus,
    output logic              addr_first,
    output logic              addr_valid
);
    logic [SELW-1:0]                sel_idx;
    logic [REG_COUNT-1:0][REG_W-1:0] reg_bank;
    logic [REG_W-1:0]               cur_val;
    logic [REG_W-1:0]               step_val;

    scratch_sel #(.SELW(SELW)) u_sel (
        .dsg_n   (dsg_n),
        .dsg_p   (dsg_p),
        .dsg_x   (dsg_x),
        .dsg_src (dsg_src),
        .sel_idx (sel_idx)
    );

    assign cur_val = reg_bank[sel_idx];

    scratch_incdec #(.REG_W(REG_W)) u_step (
        .val_in  (cur_val),
        .down    (step_down),
        .val_out (step_val)
    );

    scratch_regfile #(
        .REG_COUNT (REG_COUNT),
        .REG_W     (REG_W),
        .BYTE_W    (BYTE_W)
    ) u_rf (
        .clk      (clk),
        .rst      (rst),
        .sel_idx  (sel_idx),
        .full_we  (step_en),
        .full_val (step_val),
        .byte_we  (wr_en),
        .byte_hi  (byte_hi),
        .byte_val (wr_data),
        .bank     (reg_bank)
    );

    scratch_addr_ser #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .req   (addr_req),
        .val   (cur_val),
        .bus   (addr_bus),
        .first (addr_first),
        .valid (addr_valid)
    );

    // Accumulator read path: the selected byte, taken before the update.
    assign d_out = byte_hi ? cur_val[REG_W-1 -: BYTE_W] : cur_val[BYTE_W-1:0];
endmodule

// File: rtl/scratch_array_chk.sv
module scratch_array_chk #(
    parameter int REG_COUNT = 16,
    parameter int REG_W     = 16,
    parameter int BYTE_W    = 8,
    localparam int SELW     = $clog2(REG_COUNT)
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            addr_req,
    input logic                            addr_first,
    input logic                            addr_valid,
    input logic                            step_en,
    input logic                            step_down,
    input logic                            wr_en,
    input logic                            byte_hi,
    input logic [SELW-1:0]                 sel_idx,
    input logic [REG_COUNT-1:0][REG_W-1:0] reg_bank
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    // R1: the cycle after a reset edge, no address byte is shown.
    always_ff @(posedge clk) begin
        if (rst_q === 1'b1) begin
            p_reset_idle_r1: assert (!addr_valid);
        end
    end

    // R5: a step up adds one, with wrap-around.
    p_step_up_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_down) |=>
            reg_bank[$past(sel_idx)] == REG_W'($past(reg_bank[sel_idx]) + REG_W'(1)));

    // R6: a step down subtracts one, with wrap-around.
    p_step_down_r6: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_down) |=>
            reg_bank[$past(sel_idx)] == REG_W'($past(reg_bank[sel_idx]) - REG_W'(1)));

    // R9: in a collision the step result wins over the byte write.
    p_step_beats_write_r9: assert property (@(posedge clk) disable iff (rst)
        (step_en && wr_en && !step_down) |=>
            reg_bank[$past(sel_idx)] == REG_W'($past(reg_bank[sel_idx]) + REG_W'(1)));

    // R4: a high-byte write keeps the low byte.
    p_keep_low_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !step_en && byte_hi) |=>
            reg_bank[$past(sel_idx)][BYTE_W-1:0] == $past(reg_bank[sel_idx][BYTE_W-1:0]));

    // R7: a request is followed by the first byte.
    p_req_first_r7: assert property (@(posedge clk) disable iff (rst)
        addr_req |=> (addr_valid && addr_first));

    // R7: the first byte is followed by the second byte.
    p_first_then_second_r7: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && addr_first && !addr_req) |=> (addr_valid && !addr_first));

    // R7: with no request and no transfer in progress, the port stays idle.
    p_idle_r7: assert property (@(posedge clk) disable iff (rst)
        (!addr_req && !addr_valid) |=> !addr_valid);
endmodule

bind scratch_array scratch_array_chk #(
    .REG_COUNT (REG_COUNT),
    .REG_W     (REG_W),
    .BYTE_W    (BYTE_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_req   (addr_req),
    .addr_first (addr_first),
    .addr_valid (addr_valid),
    .step_en    (step_en),
    .step_down  (step_down),
    .wr_en      (wr_en),
    .byte_hi    (byte_hi),
    .sel_idx    (sel_idx),
    .reg_bank   (reg_bank)
);

// File: tb/scratch_array_bench.sv
module scratch_array_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] dsg_n, dsg_p, dsg_x;
    logic [1:0] dsg_src;
    logic       byte_hi;
    logic [7:0] d_out;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       step_en, step_down, addr_req;
    logic [7:0] addr_bus;
    logic       addr_first, addr_valid;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scratch_array u_scratch_array (
        .clk(clk), .rst(rst), .dsg_n(dsg_n), .dsg_p(dsg_p), .dsg_x(dsg_x),
        .dsg_src(dsg_src), .byte_hi(byte_hi), .d_out(d_out), .wr_en(wr_en),
        .wr_data(wr_data), .step_en(step_en), .step_down(step_down),
        .addr_req(addr_req), .addr_bus(addr_bus), .addr_first(addr_first),
        .addr_valid(addr_valid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 0; step_en = 0; step_down = 0; addr_req = 0;
        dsg_src = 2'd0; byte_hi = 0; wr_data = 8'h00;
    endtask

    // Reads a register through the N designator and the byte path.
    task automatic rd(input logic [3:0] idx, output logic [15:0] v);
        dsg_src = 2'd0; dsg_n = idx; byte_hi = 1; #1;
        v[15:8] = d_out;
        byte_hi = 0; #1;
        v[7:0] = d_out;
    endtask

    task automatic wr_byte(input logic [1:0] src, input logic [3:0] idx,
                           input logic hi, input logic [7:0] val);
        @(negedge clk);
        dsg_src = src; dsg_n = idx; dsg_p = idx; dsg_x = idx;
        byte_hi = hi; wr_data = val; wr_en = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic set_reg(input logic [3:0] idx, input logic [15:0] v);
        wr_byte(2'd0, idx, 1'b1, v[15:8]);
        wr_byte(2'd0, idx, 1'b0, v[7:0]);
    endtask

    task automatic step(input logic [3:0] idx, input logic down);
        @(negedge clk);
        dsg_src = 2'd0; dsg_n = idx; step_down = down; step_en = 1;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 addr_valid", {15'd0, addr_valid}, 16'd0);
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            check("R1 reg clear", v, 16'h0000);
        end
    endtask

    task automatic t_byte_write();
        logic [15:0] v;
        wr_byte(2'd0, 4'd3, 1'b1, 8'h12);
        wr_byte(2'd0, 4'd3, 1'b0, 8'h34);
        rd(4'd3, v); check("R4 both bytes", v, 16'h1234);
        wr_byte(2'd0, 4'd3, 1'b0, 8'hAB);
        rd(4'd3, v); check("R4 low write keeps high", v, 16'h12AB);
        rd(4'd2, v); check("R11 neighbour below", v, 16'h0000);
        rd(4'd4, v); check("R11 neighbour above", v, 16'h0000);
    endtask

    task automatic t_read();
        dsg_src = 0; dsg_n = 4'd3; byte_hi = 1; #1;
        check("R3 high byte", {8'h00, d_out}, 16'h0012);
        byte_hi = 0; #1;
        check("R3 low byte", {8'h00, d_out}, 16'h00AB);
    endtask

    task automatic t_sources();
        logic [15:0] v;
        set_reg(4'd5, 16'h5555);
        set_reg(4'd6, 16'h6666);
        set_reg(4'd7, 16'h7777);
        @(negedge clk);
        dsg_n = 4'd5; dsg_p = 4'd6; dsg_x = 4'd7; byte_hi = 0;
        dsg_src = 2'd0; #1; check("R2 src N", {8'h00, d_out}, 16'h0055);
        dsg_src = 2'd1; #1; check("R2 src P", {8'h00, d_out}, 16'h0066);
        dsg_src = 2'd2; #1; check("R2 src X", {8'h00, d_out}, 16'h0077);
        dsg_src = 2'd3; #1; check("R2 src 3 is X", {8'h00, d_out}, 16'h0077);
        // A page-local branch: only the low byte of the P register changes.
        wr_byte(2'd1, 4'd6, 1'b0, 8'h11);
        rd(4'd6, v); check("R4 low byte via P", v, 16'h6611);
    endtask

    task automatic t_step_up();
        logic [15:0] v;
        set_reg(4'd8, 16'hFFFF);
        step(4'd8, 1'b0);
        rd(4'd8, v); check("R5 wrap FFFF", v, 16'h0000);
        set_reg(4'd8, 16'h00FF);
        step(4'd8, 1'b0);
        rd(4'd8, v); check("R5 carry into high", v, 16'h0100);
        rd(4'd7, v); check("R11 untouched by step", v, 16'h7777);
    endtask

    task automatic t_step_down();
        logic [15:0] v;
        step(4'd9, 1'b1);
        rd(4'd9, v); check("R6 wrap 0000", v, 16'hFFFF);
        set_reg(4'd9, 16'h0100);
        step(4'd9, 1'b1);
        rd(4'd9, v); check("R6 borrow from high", v, 16'h00FF);
    endtask

    task automatic t_addr();
        logic [15:0] v;
        set_reg(4'd10, 16'hBEEF);
        @(negedge clk);
        dsg_src = 0; dsg_n = 4'd10; addr_req = 1; step_en = 1; step_down = 0;
        @(negedge clk);
        idle_inputs(); #1;
        check("R7 first byte", {6'd0, addr_valid, addr_first, addr_bus}, {6'd0, 2'b11, 8'hBE});
        @(negedge clk); #1;
        check("R8 second byte pre-step", {6'd0, addr_valid, addr_first, addr_bus}, {6'd0, 2'b10, 8'hEF});
        @(negedge clk); #1;
        check("R7 idle after two bytes", {15'd0, addr_valid}, 16'd0);
        rd(4'd10, v); check("R8 step still applied", v, 16'hBEF0);
    endtask

    task automatic t_prio();
        logic [15:0] v;
        set_reg(4'd11, 16'h1000);
        @(negedge clk);
        dsg_src = 0; dsg_n = 4'd11; step_en = 1; step_down = 0;
        wr_en = 1; byte_hi = 1; wr_data = 8'hFF;
        @(negedge clk);
        idle_inputs();
        rd(4'd11, v); check("R9 step beats write", v, 16'h1001);
    endtask

    task automatic t_all_paths();
        logic [15:0] v;
        set_reg(4'd12, 16'h40C0);
        @(negedge clk);
        dsg_src = 0; dsg_n = 4'd12; byte_hi = 1; step_en = 1; step_down = 0; addr_req = 1;
        #1; check("R10 read before update", {8'h00, d_out}, 16'h0040);
        @(negedge clk);
        idle_inputs(); #1;
        check("R10 addr high", {8'h00, addr_bus}, 16'h0040);
        @(negedge clk); #1;
        check("R10 addr low", {8'h00, addr_bus}, 16'h00C0);
        rd(4'd12, v); check("R10 stepped", v, 16'h40C1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hang expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        dsg_n = 0; dsg_p = 0; dsg_x = 0;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_byte_write();
        t_read();
        t_sources();
        t_step_up();
        t_step_down();
        t_addr();
        t_prio();
        t_all_paths();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule